// File: doc/BRIEF.md
# Multiprocessor Serial Receiver with Address Filter

An asynchronous serial receiver that takes 8-bit frames (start, eight data bits, stop) or 9-bit frames (start, eight data bits, a ninth bit, stop). The line is oversampled by a 16x sample tick. The block holds the received byte and its extra bit until software acknowledges the frame by clearing a receive-done flag.

For multidrop links, an optional hardware filter lets a frame raise receive-done only when its byte addresses this node. A byte is accepted if it equals a masked node address, or if it is a broadcast built from the OR of the address and the mask. The receiver can also flag a missing stop bit. That framing-error flag is sticky, and it shares the top bit of the control word with one of the mode bits. A select input picks which of the two that bit reads and writes.

Top module: `mp_serial_rx`

## Requirements
- R1: Mode is {ctl bit 7, ctl bit 6}: 01 receives 8-bit frames, 10 and 11 receive 9-bit frames. Data is taken LSB first. With the filter off in mode 01, `data_o` holds the byte and `bit9_o` holds the stop bit once `done_o` rises.
- R2: In modes 10 and 11, `bit9_o` holds the received ninth bit.
- R3: A stop bit sampled as 0 sets `fe_o`. Later good frames leave it set. Only a control write with `sel_fe_i`=1 changes it, and that write loads `ctl_wdata_i[7]`.
- R4: Control word layout: bit 7 is shared, bit 6 is the low mode bit, bit 5 is the filter enable, bit 4 is the receive enable, bit 2 is the stored extra bit (read only) and bit 0 is done. Bits 3 and 1 read 0. With `sel_fe_i`=1, bit 7 reads and writes `fe_o` and the high mode bit is left unchanged. With `sel_fe_i`=0, bit 7 reads and writes the high mode bit.
- R5: With the filter on, a byte matches the given address when it equals `addr_i` in every position where `mask_i` is 1.
- R6: With the filter on, a byte matches the broadcast address when it is 1 in every position where (`addr_i` | `mask_i`) is 1.
- R7: In modes 10 and 11 with the filter on, `done_o` rises only if the ninth bit is 1 and the byte matches per R5 or R6.
- R8: In mode 01 with the filter on, `done_o` rises only if the stop bit is 1 and the byte matches per R5 or R6.
- R9: With `addr_i` and `mask_i` both zero, every byte is accepted even with the filter on.
- R10: `done_o` rises halfway through the stop bit. It stays set until a control write with bit 0 = 0, and a write with bit 0 = 1 leaves it set. With the receive enable at 0, or in mode 00, no frame is received.
- R11: A start bit that reads 1 by majority at mid-bit is a false start. The receiver returns to idle and stays ready for the next falling edge.
- R12: Each bit is decided by a majority of its samples 7, 8 and 9 out of 16, so a single disturbed sample does not change the result.
- R13: A frame that completes while `done_o` is set is discarded. The held byte and extra bit are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 16x oversampling strobe |
| rxd_i | input | 1 | Serial line, idle high |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 8 | Control word write value |
| sel_fe_i | input | 1 | Shared bit 7 selects framing error (1) or high mode bit (0) |
| addr_i | input | 8 | Node address |
| mask_i | input | 8 | Node address mask |
| ctl_rdata_o | output | 8 | Control word read value |
| data_o | output | 8 | Held received byte |
| bit9_o | output | 1 | Held ninth bit or stop bit |
| done_o | output | 1 | Receive-done flag |
| fe_o | output | 1 | Sticky framing-error flag |

## Verification
The bench builds the block with its defaults: 16 samples per bit and 8 data bits, with the tick asserted on every cycle. This makes each sample land on a known clock cycle, so a single-cycle glitch can be placed exactly on the middle vote sample. It also lets the bench sweep all 256 byte values, once with the filter off and once against a fixed address/mask pair. The expected given and broadcast matches are computed arithmetically. Directed frames cover bad stop bits, false starts, overruns, disabled reception and the shared control bit.

// File: rtl/mp_rx_pkg.sv
package mp_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_NINTH,
    ST_STOP
  } rx_state_e;

  localparam logic [1:0] MODE_OFF = 2'b00;
endpackage

// File: rtl/mp_rx_sampler.sv
module mp_rx_sampler #(
  parameter int OVS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rxd_i,
  input  logic restart_i,
  output logic rxd_s_o,
  output logic decide_o,
  output logic vote_o,
  output logic bit_end_o
);
  localparam int CNT_W = $clog2(OVS);
  localparam int MID   = OVS / 2;

  logic [1:0]       sync_q;
  logic [CNT_W-1:0] phase_q;
  logic             v0_q, v1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 2'b11;
      phase_q <= '0;
      v0_q    <= 1'b1;
      v1_q    <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], rxd_i};
      if (tick_i) begin
        // detection tick is sample 0, so the next tick is sample 1
        if (restart_i)                         phase_q <= CNT_W'(1);
        else if (phase_q == CNT_W'(OVS - 1))   phase_q <= '0;
        else                                   phase_q <= phase_q + 1'b1;
        if (phase_q == CNT_W'(MID - 1)) v0_q <= sync_q[1];
        if (phase_q == CNT_W'(MID))     v1_q <= sync_q[1];
      end
    end
  end

  assign rxd_s_o   = sync_q[1];
  assign decide_o  = tick_i && !restart_i && (phase_q == CNT_W'(MID + 1));
  assign bit_end_o = tick_i && !restart_i && (phase_q == CNT_W'(OVS - 1));
  assign vote_o    = (v0_q & v1_q) | (v0_q & sync_q[1]) | (v1_q & sync_q[1]);
endmodule

// File: rtl/mp_rx_frame.sv
module mp_rx_frame
  import mp_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              nine_i,
  input  logic              tick_i,
  input  logic              rxd_s_i,
  input  logic              decide_i,
  input  logic              vote_i,
  input  logic              bit_end_i,
  output logic              idle_o,
  output logic              fdone_o,
  output logic [DATA_W-1:0] shift_o,
  output logic              ninth_o,
  output logic              stop_o
);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  rx_state_e         state_q;
  logic [BIT_W-1:0]  bcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bcnt_q  <= '0;
      fdone_o <= 1'b0;
      shift_o <= '0;
      ninth_o <= 1'b0;
      stop_o  <= 1'b1;
    end else begin
      fdone_o <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE:  if (tick_i && !rxd_s_i) state_q <= ST_START;
          ST_START: begin
            if (decide_i && vote_i) state_q <= ST_IDLE;
            else if (bit_end_i) begin
              state_q <= ST_DATA;
              bcnt_q  <= '0;
            end
          end
          ST_DATA: begin
            if (decide_i) shift_o <= {vote_i, shift_o[DATA_W-1:1]};
            if (bit_end_i) begin
              if (bcnt_q == BIT_W'(DATA_W - 1)) state_q <= nine_i ? ST_NINTH : ST_STOP;
              else bcnt_q <= bcnt_q + 1'b1;
            end
          end
          ST_NINTH: begin
            if (decide_i) ninth_o <= vote_i;
            if (bit_end_i) state_q <= ST_STOP;
          end
          ST_STOP: begin
            if (decide_i) begin
              stop_o  <= vote_i;
              fdone_o <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign idle_o = (state_q == ST_IDLE);
endmodule

// File: rtl/mp_rx_addr_match.sv
module mp_rx_addr_match #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] byte_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic              hit_o
);
  logic [DATA_W-1:0] bcast;
  logic              given_hit, bcast_hit;

  assign bcast     = addr_i | mask_i;
  assign given_hit = ((byte_i ^ addr_i) & mask_i) == '0;
  assign bcast_hit = (~byte_i & bcast) == '0;
  assign hit_o     = given_hit || bcast_hit;
endmodule

// File: rtl/mp_serial_rx.sv
module mp_serial_rx
  import mp_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              ctl_we_i,
  input  logic [7:0]        ctl_wdata_i,
  input  logic              sel_fe_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [7:0]        ctl_rdata_o,
  output logic [DATA_W-1:0] data_o,
  output logic              bit9_o,
  output logic              done_o,
  output logic              fe_o
);
  logic [1:0] mode_q;
  logic       filt_q, rxen_q;
  logic       rx_on, nine_mode;
  logic       rxd_s, decide, vote, bit_end, idle, fdone, ninth, stop, hit, accept;
  logic [DATA_W-1:0] shift;

  assign rx_on     = rxen_q && (mode_q != MODE_OFF);
  assign nine_mode = mode_q[1];

  mp_rx_sampler #(.OVS(OVS)) u_sampler (
    .clk_i, .rst_ni, .tick_i, .rxd_i,
    .restart_i (idle),
    .rxd_s_o   (rxd_s),
    .decide_o  (decide),
    .vote_o    (vote),
    .bit_end_o (bit_end)
  );

  mp_rx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk_i, .rst_ni, .tick_i,
    .en_i      (rx_on),
    .nine_i    (nine_mode),
    .rxd_s_i   (rxd_s),
    .decide_i  (decide),
    .vote_i    (vote),
    .bit_end_i (bit_end),
    .idle_o    (idle),
    .fdone_o   (fdone),
    .shift_o   (shift),
    .ninth_o   (ninth),
    .stop_o    (stop)
  );

  mp_rx_addr_match #(.DATA_W(DATA_W)) u_match (
    .byte_i (shift),
    .addr_i,
    .mask_i,
    .hit_o  (hit)
  );

  always_comb begin
    if (!filt_q)        accept = 1'b1;
    else if (nine_mode) accept = ninth && hit;
    else                accept = stop && hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      filt_q <= 1'b0;
      rxen_q <= 1'b0;
      fe_o   <= 1'b0;
      done_o <= 1'b0;
      data_o <= '0;
      bit9_o <= 1'b0;
    end else begin
      if (ctl_we_i) begin
        if (sel_fe_i) fe_o      <= ctl_wdata_i[7];
        else          mode_q[1] <= ctl_wdata_i[7];
        mode_q[0] <= ctl_wdata_i[6];
        filt_q    <= ctl_wdata_i[5];
        rxen_q    <= ctl_wdata_i[4];
        if (!ctl_wdata_i[0]) done_o <= 1'b0;
      end
      if (fdone && rx_on) begin
        if (!stop) fe_o <= 1'b1;
        if (accept && !done_o) begin
          data_o <= shift;
          bit9_o <= nine_mode ? ninth : stop;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign ctl_rdata_o = {sel_fe_i ? fe_o : mode_q[1], mode_q[0], filt_q, rxen_q,
                        1'b0, bit9_o, 1'b0, done_o};
endmodule

// File: rtl/mp_serial_rx_chk.sv
module mp_serial_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctl_we_i,
  input logic [7:0]        ctl_wdata_i,
  input logic              sel_fe_i,
  input logic [DATA_W-1:0] addr_i,
  input logic [DATA_W-1:0] mask_i,
  input logic [DATA_W-1:0] data_o,
  input logic              bit9_o,
  input logic              done_o,
  input logic              fe_o,
  input logic [1:0]        mode_q,
  input logic              filt_q,
  input logic              rx_on
);
  p_fe_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fe_o && !(ctl_we_i && sel_fe_i)) |=> fe_o);

  p_mode_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && sel_fe_i) |=> $stable(mode_q[1]));

  p_done_held_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !(ctl_we_i && !ctl_wdata_i[0])) |=> done_o);

  p_no_rx_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(rx_on));

  p_keep_held_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> $stable(data_o) && $stable(bit9_o));

  p_ninth_addr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(done_o) && $past(filt_q) && $past(mode_q[1])) |-> bit9_o);

  p_stop_addr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(done_o) && $past(filt_q) && ($past(mode_q) == 2'b01)) |-> bit9_o);

  // R5 / R6: accepted byte under filter is a given or broadcast match
  p_match_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(done_o) && $past(filt_q)) |->
      ((((data_o ^ $past(addr_i)) & $past(mask_i)) == '0) ||
       ((data_o & ($past(addr_i) | $past(mask_i))) == ($past(addr_i) | $past(mask_i)))));
endmodule

bind mp_serial_rx mp_serial_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctl_we_i    (ctl_we_i),
  .ctl_wdata_i (ctl_wdata_i),
  .sel_fe_i    (sel_fe_i),
  .addr_i      (addr_i),
  .mask_i      (mask_i),
  .data_o      (data_o),
  .bit9_o      (bit9_o),
  .done_o      (done_o),
  .fe_o        (fe_o),
  .mode_q      (mode_q),
  .filt_q      (filt_q),
  .rx_on       (rx_on)
);

// File: tb/test_mp_serial_rx.sv
module test_mp_serial_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic       sel_fe = 1'b0;
  logic [7:0] addr = '0, mask = '0;
  logic [7:0] ctl_rdata, data;
  logic       bit9, done, fe;
  int         n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  mp_serial_rx i_mp_serial_rx (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(1'b1), .rxd_i(rxd),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata), .sel_fe_i(sel_fe),
    .addr_i(addr), .mask_i(mask), .ctl_rdata_o(ctl_rdata),
    .data_o(data), .bit9_o(bit9), .done_o(done), .fe_o(fe)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cfg(logic [1:0] m, logic f, logic e);
    return {m, f, e, 4'b0000};
  endfunction

  task automatic ctl_write(logic [7:0] w, logic s);
    sel_fe = s; ctl_wdata = w; ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0; sel_fe = 1'b0;
    @(negedge clk);
  endtask

  task automatic drive_bit(logic v, logic glitch);
    for (int i = 0; i < 16; i++) begin
      rxd = (glitch && i == 8) ? ~v : v;
      @(negedge clk);
    end
  endtask

  // gbit: index of data bit to disturb at sample 8, -1 for none
  task automatic send(logic [7:0] b, logic has9, logic b9, logic stopv, int gbit);
    drive_bit(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) drive_bit(b[i], gbit == i);
    if (has9) drive_bit(b9, 1'b0);
    drive_bit(stopv, 1'b0);
    rxd = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  function automatic logic hit(logic [7:0] b, logic [7:0] a, logic [7:0] m);
    return (((b ^ a) & m) == 0) || ((b & (a | m)) == (a | m));
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset done", done, 0);
    chk("reset fe", fe, 0);
    chk("reset data", data, 0);
    chk("reset ctl R4", ctl_rdata, 0);

    // R1: all bytes, 8-bit mode, no filter
    ctl_write(cfg(2'b01, 0, 1), 0);
    for (int b = 0; b < 256; b++) begin
      send(8'(b), 0, 0, 1, -1);
      chk("R1 data", data, b);
      chk("R1 stop in bit9", bit9, 1);
      chk("R10 done set", done, 1);
      ctl_write(cfg(2'b01, 0, 1), 0);
    end
    chk("R3 good frames leave fe clear", fe, 0);

    // R2: ninth bit
    ctl_write(cfg(2'b10, 0, 1), 0);
    send(8'hA5, 1, 0, 1, -1);
    chk("R2 data", data, 8'hA5);
    chk("R2 ninth 0", bit9, 0);
    chk("R4 ctl bit2", ctl_rdata[2], 0);
    ctl_write(cfg(2'b10, 0, 1), 0);
    send(8'h5A, 1, 1, 1, -1);
    chk("R2 ninth 1", bit9, 1);
    chk("R4 ctl bit2", ctl_rdata[2], 1);

    // R5 R6 R7: filter sweep in 9-bit mode
    addr = 8'hC0; mask = 8'hFD;
    ctl_write(cfg(2'b11, 1, 1), 0);
    for (int b = 0; b < 256; b++) begin
      send(8'(b), 1, 1, 1, -1);
      chk("R5 R6 R7 accept", done, hit(8'(b), addr, mask));
      if (done) chk("R5 R6 data", data, b);
      ctl_write(cfg(2'b11, 1, 1), 0);
    end
    send(8'hC0, 1, 0, 1, -1);
    chk("R7 ninth 0 rejected", done, 0);

    // R9: zero address and mask accept all
    addr = 8'h00; mask = 8'h00;
    ctl_write(cfg(2'b10, 1, 1), 0);
    send(8'h00, 1, 1, 1, -1);
    chk("R9 00", done, 1);
    ctl_write(cfg(2'b10, 1, 1), 0);
    send(8'h6B, 1, 1, 1, -1);
    chk("R9 6B", done, 1);
    chk("R9 data", data, 8'h6B);

    // R8: 8-bit filter needs stop and match
    addr = 8'hC0; mask = 8'hFD;
    ctl_write(cfg(2'b01, 1, 1), 0);
    send(8'h12, 0, 0, 1, -1);
    chk("R8 no match", done, 0);
    send(8'hC2, 0, 0, 1, -1);
    chk("R8 match", done, 1);
    chk("R8 data", data, 8'hC2);
    ctl_write(cfg(2'b01, 1, 1), 0);
    send(8'hC0, 0, 0, 0, -1);
    chk("R8 bad stop rejected", done, 0);
    chk("R3 bad stop sets fe", fe, 1);

    // R3: sticky through good frame
    ctl_write(cfg(2'b01, 0, 1), 0);
    send(8'h3C, 0, 0, 1, -1);
    chk("R3 fe sticky", fe, 1);
    sel_fe = 1'b1; @(negedge clk);
    chk("R4 bit7 shows fe", ctl_rdata[7], 1);
    sel_fe = 1'b0; @(negedge clk);
    chk("R4 bit7 shows mode", ctl_rdata[7], 0);

    // R4: shared bit writes
    ctl_write(cfg(2'b11, 0, 1), 0);
    ctl_write(8'h50, 1);
    chk("R3 fe cleared by write", fe, 0);
    chk("R4 mode kept", ctl_rdata[7:4], 4'b1101);
    ctl_write(8'h50 | 8'h80, 1);
    chk("R3 fe written 1", fe, 1);
    ctl_write(8'h50, 1);

    // R13: overrun discards
    ctl_write(cfg(2'b01, 0, 1), 0);
    send(8'h11, 0, 0, 1, -1);
    send(8'h22, 0, 0, 0, -1);
    chk("R13 held data", data, 8'h11);
    chk("R13 held bit9", bit9, 1);
    repeat (100) @(negedge clk);
    chk("R10 done persists", done, 1);
    ctl_write(cfg(2'b01, 0, 1) | 8'h01, 0);
    chk("R10 write 1 keeps done", done, 1);

    // R10: disabled reception
    ctl_write(cfg(2'b01, 0, 0), 0);
    send(8'h33, 0, 0, 1, -1);
    chk("R10 disabled no done", done, 0);
    chk("R10 disabled data", data, 8'h11);
    ctl_write(cfg(2'b00, 0, 1), 0);
    send(8'h44, 0, 0, 1, -1);
    chk("R10 mode 00 no done", done, 0);

    // R11: false start
    ctl_write(cfg(2'b01, 0, 1), 0);
    rxd = 1'b0; repeat (5) @(negedge clk);
    rxd = 1'b1; repeat (30) @(negedge clk);
    chk("R11 false start", done, 0);
    send(8'h6C, 0, 0, 1, -1);
    chk("R11 next frame", data, 8'h6C);

    // R12: single disturbed vote sample
    ctl_write(cfg(2'b01, 0, 1), 0);
    send(8'h0F, 0, 0, 1, 0);
    chk("R12 glitch bit0", data, 8'h0F);
    ctl_write(cfg(2'b01, 0, 1), 0);
    send(8'h0F, 0, 0, 1, 7);
    chk("R12 glitch bit7", data, 8'h0F);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule